// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the data port of a 32-bit processor and memories that are organised as 32-bit words. Each request carries an address, an access size, a write flag, the store data, and the raw word that memory returned at the word-aligned location. The block does not raise faults. Misaligned loads are rotated, and misaligned stores are forced onto their natural boundary. The block works out the effective memory address, the byte enables and the lane-replicated store data. Load data leaves the block zero-extended. Sign extension is left to the consumer.

Some address regions have rules of their own. In the video region, addresses are folded into a 128 KiB window. A byte store to the lower part of that window is widened so that the byte is written to both lanes of its halfword. A byte store to the upper part of the window, or to the object attribute region, is dropped. The register region answers a byte read with a halfword access. It answers a word read with a pair of halfword accesses.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream. When `REG_OUT` is 1 there is one register stage. That stage accepts a new request whenever it is empty or its result is being taken in the same cycle. A stalled result holds every output field. When `REG_OUT` is 0 the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `aln_core`

## Requirements
- R1: A word load (`in_size` 2 or 3) returns the raw word rotated right by 8 × `in_addr[1:0]` bits. The effective address has bits [1:0] cleared, except for a register-region word load (see R4).
- R2: A halfword load (`in_size` 1) selects the upper raw halfword when `in_addr[1]`=1 and the lower one otherwise. It swaps the two bytes of that halfword when `in_addr[0]`=1 and zero-extends the result. The effective address has bit 0 cleared.
- R3: A byte load (`in_size` 0) returns raw byte lane `in_addr[1:0]`, zero-extended. In the register region (`in_addr[31:24]`=0x04) the effective address has bit 0 cleared. Elsewhere the address is unchanged.
- R4: A word load in the register region sets `out_pair`. It gives `in_addr` with only bit 1 cleared as the first halfword address; the second halfword is at that address with bit 1 set. Every other access has `out_pair`=0.
- R5: A word store gives byte enables 4'b1111, clears address bits [1:0] and passes the store data unchanged.
- R6: A halfword store gives enables 4'b1100 when `in_addr[1]`=1 and 4'b0011 otherwise. It clears address bit 0 and replicates `in_wdata[15:0]` into both halves.
- R7: Outside the video and object regions, a byte store enables only lane `in_addr[1:0]`, keeps the address, and replicates `in_wdata[7:0]` into all four lanes.
- R8: A byte store to the video region (`in_addr[31:24]`=0x06) whose folded offset is below 0x18000 enables both lanes of its halfword (4'b1100 or 4'b0011 by `in_addr[1]`) and clears address bit 0.
- R9: A byte store to the video region with folded offset at or above 0x18000, or to the object region (`in_addr[31:24]`=0x07), sets `out_suppress` with enables 4'b0000. Halfword and word stores there are never suppressed.
- R10: For any video-region access the effective address keeps bits [31:24] and replaces bits [23:0] with `in_addr[16:0]` zero-extended (mask 0x1FFFF). Alignment is then applied.
- R11: Loads drive enables 4'b0000, `out_suppress`=0 and `out_wdata`=0. Stores drive `out_rdata`=0. `out_write` mirrors `in_write`.
- R12: With `REG_OUT`=1 a request accepted at an edge appears on the outputs after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, all outputs hold.
- R13: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Byte address of the access |
| in_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| in_write | input | 1 | 1 store, 0 load |
| in_wdata | input | 32 | Store data, right-justified |
| in_raw | input | 32 | Raw word read at the aligned location |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective, aligned memory address |
| out_be | output | 4 | Byte-lane write enables |
| out_wdata | output | 32 | Lane-replicated store data |
| out_rdata | output | 32 | Rotated, zero-extended load data |
| out_suppress | output | 1 | Store dropped by region rule |
| out_pair | output | 1 | Word read split into two halfword reads |
| out_write | output | 1 | Copy of the request's write flag |

## Verification
The bench builds the block with its default parameters: `REG_OUT`=1, the tags 0x04, 0x06 and 0x07, a video fold mask of 0x1FFFF and a split at 0x18000. The registered stage makes the stall path reachable, so the bench can hold a result while a second request waits, check that `in_ready` falls, and then release both in order. The default fold and split values make the mirrored video addresses and the exact boundary offsets 0x17FFF, 0x18000 and 0x18001 into directed cases.

// File: rtl/aln_pkg.sv
package aln_pkg;
  localparam int ALN_DW    = 32;
  localparam int ALN_LANES = ALN_DW / 8;
  localparam int ALN_LSB   = $clog2(ALN_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_PLAIN = 2'd0,
    RG_IO    = 2'd1,
    RG_VIDEO = 2'd2,
    RG_OBJ   = 2'd3
  } region_e;

  typedef struct packed {
    logic [ALN_DW-1:0]    addr;
    logic [ALN_LANES-1:0] be;
    logic [ALN_DW-1:0]    wdata;
    logic [ALN_DW-1:0]    rdata;
    logic                 suppress;
    logic                 pair;
    logic                 write;
  } aln_result_t;
endpackage

// File: rtl/aln_region_dec.sv
module aln_region_dec
  import aln_pkg::*;
#(
  parameter logic [7:0]  IO_TAG    = 8'h04,
  parameter logic [7:0]  VID_TAG   = 8'h06,
  parameter logic [7:0]  OBJ_TAG   = 8'h07,
  parameter logic [23:0] VID_MASK  = 24'h01FFFF,
  parameter logic [23:0] VID_SPLIT = 24'h018000
) (
  input  logic [ALN_DW-1:0] addr,
  output region_e           region,
  output logic              vid_upper,
  output logic [ALN_DW-1:0] eff_addr
);
  logic [7:0]  tag;
  logic [23:0] vid_off;

  assign tag     = addr[31:24];
  assign vid_off = addr[23:0] & VID_MASK;

  always_comb begin
    if (tag == IO_TAG)       region = RG_IO;
    else if (tag == VID_TAG) region = RG_VIDEO;
    else if (tag == OBJ_TAG) region = RG_OBJ;
    else                     region = RG_PLAIN;
  end

  assign vid_upper = (region == RG_VIDEO) && (vid_off >= VID_SPLIT);
  assign eff_addr  = (region == RG_VIDEO) ? {tag, vid_off} : addr;
endmodule

// File: rtl/aln_load_rot.sv
module aln_load_rot
  import aln_pkg::*;
(
  input  acc_size_e          size,
  input  logic [ALN_LSB-1:0] sel,
  input  logic [ALN_DW-1:0]  raw,
  output logic [ALN_DW-1:0]  rdata
);
  logic [7:0]        lane [ALN_LANES];
  logic [ALN_DW-1:0] rot  [ALN_LANES];
  logic [15:0]       half;

  for (genvar g = 0; g < ALN_LANES; g++) begin : g_lane
    assign lane[g] = raw[8*g +: 8];
    if (g == 0) begin : g_r0
      assign rot[g] = raw;
    end else begin : g_rn
      assign rot[g] = {raw[8*g-1:0], raw[ALN_DW-1:8*g]};
    end
  end

  assign half = sel[1] ? raw[31:16] : raw[15:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: rdata = {{(ALN_DW-8){1'b0}}, lane[sel]};
      SZ_HALF: rdata = sel[0] ? {16'h0000, half[7:0], half[15:8]}
                              : {16'h0000, half};
      default: rdata = rot[sel];
    endcase
  end
endmodule

// File: rtl/aln_store_lane.sv
module aln_store_lane
  import aln_pkg::*;
(
  input  acc_size_e            size,
  input  logic [ALN_LSB-1:0]   sel,
  input  logic [ALN_DW-1:0]    wdata,
  input  region_e              region,
  input  logic                 vid_upper,
  output logic [ALN_LANES-1:0] be,
  output logic [ALN_DW-1:0]    lane_data,
  output logic                 suppress,
  output logic [ALN_LSB-1:0]   clr
);
  logic [ALN_LANES-1:0] half_be;

  assign half_be = sel[1] ? 4'b1100 : 4'b0011;

  always_comb begin
    be        = '0;
    lane_data = '0;
    suppress  = 1'b0;
    clr       = '0;
    unique case (size)
      SZ_BYTE: begin
        lane_data = {ALN_LANES{wdata[7:0]}};
        if (region == RG_OBJ || vid_upper) begin
          suppress = 1'b1;
        end else if (region == RG_VIDEO) begin
          be  = half_be;
          clr = 2'b01;
        end else begin
          be = 4'b0001 << sel;
        end
      end
      SZ_HALF: begin
        lane_data = {2{wdata[15:0]}};
        be        = half_be;
        clr       = 2'b01;
      end
      default: begin
        lane_data = wdata;
        be        = '1;
        clr       = 2'b11;
      end
    endcase
  end
endmodule

// File: rtl/aln_core.sv
module aln_core
  import aln_pkg::*;
#(
  parameter bit          REG_OUT   = 1'b1,
  parameter logic [7:0]  IO_TAG    = 8'h04,
  parameter logic [7:0]  VID_TAG   = 8'h06,
  parameter logic [7:0]  OBJ_TAG   = 8'h07,
  parameter logic [23:0] VID_MASK  = 24'h01FFFF,
  parameter logic [23:0] VID_SPLIT = 24'h018000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_addr,
  input  logic [1:0]  in_size,
  input  logic        in_write,
  input  logic [31:0] in_wdata,
  input  logic [31:0] in_raw,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_addr,
  output logic [3:0]  out_be,
  output logic [31:0] out_wdata,
  output logic [31:0] out_rdata,
  output logic        out_suppress,
  output logic        out_pair,
  output logic        out_write
);
  acc_size_e            sz;
  region_e              region;
  logic                 vid_upper;
  logic [ALN_DW-1:0]    eff_addr;
  logic [ALN_DW-1:0]    rot_data;
  logic [ALN_LANES-1:0] st_be;
  logic [ALN_DW-1:0]    st_data;
  logic                 st_supp;
  logic [ALN_LSB-1:0]   st_clr;
  logic [ALN_LSB-1:0]   ld_clr;
  logic                 is_word;
  aln_result_t          nxt;
  aln_result_t          res;

  assign sz      = acc_size_e'(in_size);
  assign is_word = (sz == SZ_WORD) || (sz == SZ_WIDE);

  aln_region_dec #(
    .IO_TAG(IO_TAG), .VID_TAG(VID_TAG), .OBJ_TAG(OBJ_TAG),
    .VID_MASK(VID_MASK), .VID_SPLIT(VID_SPLIT)
  ) u_dec (
    .addr(in_addr), .region(region), .vid_upper(vid_upper), .eff_addr(eff_addr)
  );

  aln_load_rot u_rot (
    .size(sz), .sel(in_addr[ALN_LSB-1:0]), .raw(in_raw), .rdata(rot_data)
  );

  aln_store_lane u_st (
    .size(sz), .sel(in_addr[ALN_LSB-1:0]), .wdata(in_wdata), .region(region),
    .vid_upper(vid_upper), .be(st_be), .lane_data(st_data),
    .suppress(st_supp), .clr(st_clr)
  );

  // Load alignment: register-space words split into halfword pair, bytes read as halfword
  always_comb begin
    if (is_word)              ld_clr = (region == RG_IO) ? 2'b10 : 2'b11;
    else if (sz == SZ_HALF)   ld_clr = 2'b01;
    else if (region == RG_IO) ld_clr = 2'b01;
    else                      ld_clr = 2'b00;
  end

  always_comb begin
    nxt.write = in_write;
    if (in_write) begin
      nxt.addr     = eff_addr & ~{{(ALN_DW-ALN_LSB){1'b0}}, st_clr};
      nxt.be       = st_be;
      nxt.wdata    = st_data;
      nxt.rdata    = '0;
      nxt.suppress = st_supp;
      nxt.pair     = 1'b0;
    end else begin
      nxt.addr     = eff_addr & ~{{(ALN_DW-ALN_LSB){1'b0}}, ld_clr};
      nxt.be       = '0;
      nxt.wdata    = '0;
      nxt.rdata    = rot_data;
      nxt.suppress = 1'b0;
      nxt.pair     = is_word && (region == RG_IO);
    end
  end

  if (REG_OUT) begin : g_reg
    aln_result_t held;
    logic        vld;

    assign in_ready = !vld || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld  <= 1'b0;
        held <= '0;
      end else if (in_ready) begin
        vld <= in_valid;
        if (in_valid) held <= nxt;
      end
    end

    assign out_valid = vld;
    assign res       = held;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign res       = nxt;
  end

  assign out_addr     = res.addr;
  assign out_be       = res.be;
  assign out_wdata    = res.wdata;
  assign out_rdata    = res.rdata;
  assign out_suppress = res.suppress;
  assign out_pair     = res.pair;
  assign out_write    = res.write;
endmodule

// File: rtl/aln_core_chk.sv
module aln_core_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_addr,
  input logic [3:0]  out_be,
  input logic [31:0] out_wdata,
  input logic [31:0] out_rdata,
  input logic        out_suppress,
  input logic        out_pair,
  input logic        out_write
);
  p_supp_nolanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_suppress |-> out_be == 4'b0000 && out_write);

  p_load_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_write |-> out_be == 4'b0000 && !out_suppress && out_wdata == 32'h0);

  p_store_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write && !out_suppress |->
      ($countones(out_be) == 1 || $countones(out_be) == 2 || $countones(out_be) == 4));

  p_pair_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pair |-> !out_write);

  p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write && out_be == 4'b1111 |-> out_addr[1:0] == 2'b00);

  if (REG_OUT) begin : g_seq
    p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
        && $stable(out_wdata) && $stable(out_rdata));

    p_empty_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

    p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
  end
endmodule

bind aln_core aln_core_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/aln_core_tb.sv
module aln_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_size = '0;
  logic        in_write = 1'b0;
  logic [31:0] in_wdata = '0;
  logic [31:0] in_raw = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [3:0]  out_be;
  logic [31:0] out_wdata;
  logic [31:0] out_rdata;
  logic        out_suppress;
  logic        out_pair;
  logic        out_write;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  aln_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_write(in_write),
    .in_wdata(in_wdata), .in_raw(in_raw), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_be(out_be),
    .out_wdata(out_wdata), .out_rdata(out_rdata), .out_suppress(out_suppress),
    .out_pair(out_pair), .out_write(out_write)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] s, input logic w,
                       input logic [31:0] wd, input logic [31:0] raw);
    in_addr = a; in_size = s; in_write = w; in_wdata = wd; in_raw = raw;
  endtask

  // one request through the stage, result checked at the following falling edge
  task automatic send(input logic [31:0] a, input logic [1:0] s, input logic w,
                      input logic [31:0] wd, input logic [31:0] raw);
    @(negedge clk);
    drive(a, s, w, wd, raw);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R13 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R13 in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_word_load;
    send(32'h0300_0000, 2'd2, 1'b0, 32'h0, 32'h4433_2211);
    chk("R1 rot0", out_rdata, 32'h4433_2211);
    chk("R1 valid", {31'h0, out_valid}, 32'h1);
    send(32'h0300_0001, 2'd2, 1'b0, 32'h0, 32'h4433_2211);
    chk("R1 rot1", out_rdata, 32'h1144_3322);
    chk("R1 addr", out_addr, 32'h0300_0000);
    chk("R11 load be", {28'h0, out_be}, 32'h0);
    chk("R4 no pair", {31'h0, out_pair}, 32'h0);
    send(32'h0300_0002, 2'd3, 1'b0, 32'h0, 32'h4433_2211);
    chk("R1 rot2", out_rdata, 32'h2211_4433);
    send(32'h0300_0003, 2'd2, 1'b0, 32'h0, 32'h4433_2211);
    chk("R1 rot3", out_rdata, 32'h3322_1144);
    chk("R11 write flag", {31'h0, out_write}, 32'h0);
  endtask

  task automatic t_half_load;
    send(32'h0300_0002, 2'd1, 1'b0, 32'h0, 32'h4433_2211);
    chk("R2 upper", out_rdata, 32'h0000_4433);
    send(32'h0300_0003, 2'd1, 1'b0, 32'h0, 32'h4433_2211);
    chk("R2 upper swap", out_rdata, 32'h0000_3344);
    chk("R2 addr", out_addr, 32'h0300_0002);
    send(32'h0300_0001, 2'd1, 1'b0, 32'h0, 32'h4433_2211);
    chk("R2 lower swap", out_rdata, 32'h0000_1122);
  endtask

  task automatic t_byte_load;
    send(32'h0300_0002, 2'd0, 1'b0, 32'h0, 32'h4433_2211);
    chk("R3 lane2", out_rdata, 32'h0000_0033);
    chk("R3 addr kept", out_addr, 32'h0300_0002);
    send(32'h0400_0003, 2'd0, 1'b0, 32'h0, 32'hF4E3_D2C1);
    chk("R3 io lane3", out_rdata, 32'h0000_00F4);
    chk("R3 io addr", out_addr, 32'h0400_0002);
  endtask

  task automatic t_io_word;
    send(32'h0400_0006, 2'd2, 1'b0, 32'h0, 32'hA1B2_C3D4);
    chk("R4 pair", {31'h0, out_pair}, 32'h1);
    chk("R4 addr", out_addr, 32'h0400_0004);
    chk("R4 rot", out_rdata, 32'hC3D4_A1B2);
    send(32'h0400_0005, 2'd2, 1'b0, 32'h0, 32'hA1B2_C3D4);
    chk("R4 addr odd", out_addr, 32'h0400_0005);
  endtask

  task automatic t_word_store;
    send(32'h0200_0007, 2'd2, 1'b1, 32'hDEAD_BEEF, 32'h0);
    chk("R5 be", {28'h0, out_be}, 32'hF);
    chk("R5 addr", out_addr, 32'h0200_0004);
    chk("R5 data", out_wdata, 32'hDEAD_BEEF);
    chk("R11 store rdata", out_rdata, 32'h0);
    chk("R11 write flag", {31'h0, out_write}, 32'h1);
  endtask

  task automatic t_half_store;
    send(32'h0200_0003, 2'd1, 1'b1, 32'h1234_ABCD, 32'h0);
    chk("R6 be hi", {28'h0, out_be}, 32'hC);
    chk("R6 addr", out_addr, 32'h0200_0002);
    chk("R6 data", out_wdata, 32'hABCD_ABCD);
    send(32'h0200_0001, 2'd1, 1'b1, 32'h0000_0F0F, 32'h0);
    chk("R6 be lo", {28'h0, out_be}, 32'h3);
    chk("R6 addr lo", out_addr, 32'h0200_0000);
  endtask

  task automatic t_byte_store;
    send(32'h0200_0002, 2'd0, 1'b1, 32'hFFFF_FF5A, 32'h0);
    chk("R7 be", {28'h0, out_be}, 32'h4);
    chk("R7 data", out_wdata, 32'h5A5A_5A5A);
    chk("R7 addr", out_addr, 32'h0200_0002);
    chk("R7 supp", {31'h0, out_suppress}, 32'h0);
    send(32'h0400_0001, 2'd0, 1'b1, 32'h0000_0077, 32'h0);
    chk("R7 io be", {28'h0, out_be}, 32'h2);
  endtask

  task automatic t_video_byte;
    send(32'h06F0_0005, 2'd0, 1'b1, 32'h0000_00C3, 32'h0);
    chk("R8 be", {28'h0, out_be}, 32'h3);
    chk("R10 fold addr", out_addr, 32'h0600_0004);
    chk("R8 data", out_wdata, 32'hC3C3_C3C3);
    send(32'h0601_7FFF, 2'd0, 1'b1, 32'h0000_0011, 32'h0);
    chk("R8 edge be", {28'h0, out_be}, 32'hC);
    chk("R8 edge addr", out_addr, 32'h0601_7FFE);
    chk("R8 edge supp", {31'h0, out_suppress}, 32'h0);
    send(32'h0602_0010, 2'd2, 1'b0, 32'h0, 32'h0);
    chk("R10 load fold", out_addr, 32'h0600_0010);
  endtask

  task automatic t_suppress;
    send(32'h0601_8000, 2'd0, 1'b1, 32'h0000_0099, 32'h0);
    chk("R9 split supp", {31'h0, out_suppress}, 32'h1);
    chk("R9 split be", {28'h0, out_be}, 32'h0);
    send(32'h0603_8001, 2'd0, 1'b1, 32'h0000_0099, 32'h0);
    chk("R9 mirror supp", {31'h0, out_suppress}, 32'h1);
    send(32'h0700_0001, 2'd0, 1'b1, 32'h0000_0099, 32'h0);
    chk("R9 obj supp", {31'h0, out_suppress}, 32'h1);
    chk("R9 obj be", {28'h0, out_be}, 32'h0);
    send(32'h0601_8000, 2'd1, 1'b1, 32'h0000_BEEF, 32'h0);
    chk("R9 half kept", {31'h0, out_suppress}, 32'h0);
    chk("R9 half be", {28'h0, out_be}, 32'h3);
    send(32'h0700_0004, 2'd2, 1'b1, 32'h0102_0304, 32'h0);
    chk("R9 obj word be", {28'h0, out_be}, 32'hF);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    drive(32'h0300_0000, 2'd0, 1'b0, 32'h0, 32'h0000_00AA);
    in_valid = 1'b1;
    @(negedge clk);
    drive(32'h0300_0001, 2'd0, 1'b0, 32'h0, 32'h0000_BB00);
    #1;
    chk("R12 first out", out_rdata, 32'h0000_00AA);
    chk("R12 ready low", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R12 hold data", out_rdata, 32'h0000_00AA);
    chk("R12 hold valid", {31'h0, out_valid}, 32'h1);
    out_ready = 1'b1;
    #1;
    chk("R12 ready pass", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R12 second out", out_rdata, 32'h0000_00BB);
    @(negedge clk);
    #1;
    chk("R12 drained", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_word_load();
    t_half_load();
    t_byte_load();
    t_io_word();
    t_word_store();
    t_half_store();
    t_byte_store();
    t_video_byte();
    t_suppress();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule